// File: doc/BRIEF.md
# External Interrupt Request Controller

This block stands between two active-low external interrupt pins and a CPU core. One pin carries a maskable request. The other carries a non-maskable request that software can switch on only once. The block also accepts a software-interrupt strobe from the core. It decides which request is pending and raises a single request flag towards the core. Alongside that flag it presents the 16-bit address of the two-byte vector that the core must fetch. When the core takes the interrupt, it pulses an acknowledge strobe.

The block holds the two condition-code mask bits that gate these requests. The global mask gates the maskable pin. The non-maskable mask gates the other pin and, once cleared, cannot be set again by software. The core drives set and clear ports for both bits. The block also holds a small control register with two fields: a local enable for the maskable pin, and a select between active-low level and falling-edge triggering.

Both pins pass through a two-flop synchronizer. A falling edge seen in edge mode is held until it is acknowledged. A state machine with three states orders the outputs. ST_BOOT is entered at reset and shows the reset vector. ST_REQ is held while any request is active. ST_IDLE is entered once all requests have been served. The transitions are:
- ST_BOOT to ST_REQ, and ST_IDLE to ST_REQ, when a request becomes active.
- ST_REQ to ST_REQ while a request remains active.
- ST_REQ to ST_IDLE when no request remains after an acknowledge or a release.

Top module: `ext_int_ctrl`

## Requirements
- R1: After reset, `int_req` is 0 and `int_vec` is 16'hFFFE, and both mask bits are 1. The control register selects level mode with the maskable pin disabled. With these values, neither pin raises a request.
- R2: While `int_req` is 1, `int_vec` names the winning source:
  - 16'hFFF6 for the software interrupt.
  - 16'hFFF4 for the non-maskable pin.
  - 16'hFFF2 for the maskable pin.

  While `int_req` is 0, `int_vec` holds its last value.
- R3: When several sources are active in the same cycle, the software interrupt wins over the non-maskable pin, and the non-maskable pin wins over the maskable pin.
- R4: The maskable pin raises a request only if two conditions both hold: control bit 6 (local enable) is 1, and the global mask is 0. A set global mask blocks the pin whatever the local enable holds.
- R5: With control bit 7 at 0 (level mode), the maskable request is asserted while the synchronized pin is low. `int_req` rises on the third rising clock edge after the pin goes low, and falls by the same delay after the pin is released.
- R6: With control bit 7 at 1 (edge mode), a high-to-low transition of the maskable pin is held until an acknowledge takes it. A pin that is still held low after the acknowledge does not raise a new request.
- R7: The non-maskable pin is active-low level only. It is gated only by its own mask, and neither the global mask nor the control register affects it.
- R8: A pulse on `nmask_clr` clears the non-maskable mask. After that, pulses on `nmask_set` are ignored until reset.
- R9: A pulse on `swi_stb` raises `int_req` with vector 16'hFFF6 at the next clock edge, whatever the state of either mask.
- R10: An acknowledge (`int_ack` while `int_req` is 1) has the following effects:
  - It sets the global mask.
  - It also sets the non-maskable mask when the non-maskable pin was the source taken.
  - It retires a pending software interrupt or held edge of the source taken.
  - An acknowledge while `int_req` is 0 has no effect.
- R11: `gmask_set` and `gmask_clr` set and clear the global mask. When both are pulsed in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mirq_pin_n | input | 1 | Maskable external request pin, active low |
| nmi_pin_n | input | 1 | Non-maskable external request pin, active low |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Control write data: bit 7 selects edge mode, bit 6 is the local enable |
| gmask_set | input | 1 | Sets the global mask |
| gmask_clr | input | 1 | Clears the global mask |
| nmask_set | input | 1 | Requests a set of the non-maskable mask (ignored once the mask is cleared) |
| nmask_clr | input | 1 | Clears the non-maskable mask |
| swi_stb | input | 1 | Software-interrupt strobe |
| int_ack | input | 1 | Acknowledge of the presented request |
| int_req | output | 1 | Interrupt request to the core |
| int_vec | output | 16 | Vector address for the core to fetch |

## Verification
The assertions check the following on every cycle:
- The reset vector is shown while the block is still in ST_BOOT.
- A request always carries one of the three source vectors.
- A software strobe produces its request at the next edge.
- An acknowledge sets the global mask.
- A cleared non-maskable mask stays cleared against software set attempts.
- The edge latch is held until it is cleared, and is empty after a clear.

Only the bench's scenarios can show the following:
- The three-edge synchronizer delay.
- Priority between sources that arrive together.
- Blocking by the local enable and by the global mask.
- That a pin held low after an edge is acknowledged does not retrigger.
- That an acknowledge with no request pending leaves the masks untouched.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int VEC_W       = 16;
    localparam int CFG_W       = 8;
    localparam int CFG_EDGE_B  = 7;
    localparam int CFG_EN_B    = 6;
    localparam int SYNC_STAGES = 2;

    localparam logic [VEC_W-1:0] VEC_RESET = 16'hFFFE;
    localparam logic [VEC_W-1:0] VEC_SWI   = 16'hFFF6;
    localparam logic [VEC_W-1:0] VEC_NMI   = 16'hFFF4;
    localparam logic [VEC_W-1:0] VEC_MIRQ  = 16'hFFF2;

    typedef enum logic [1:0] {SRC_NONE, SRC_SWI, SRC_NMI, SRC_MIRQ} src_e;
    typedef enum logic [1:0] {ST_BOOT, ST_IDLE, ST_REQ} state_e;

    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        logic [VEC_W-1:0] v;
        unique case (s)
            SRC_SWI:  v = VEC_SWI;
            SRC_NMI:  v = VEC_NMI;
            SRC_MIRQ: v = VEC_MIRQ;
            default:  v = VEC_RESET;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int   WIDTH  = 2,
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= {WIDTH{IDLE}};
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= {WIDTH{IDLE}};
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eic_edge_latch.sv
module eic_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic fall_o,
    output logic held_o
);
    logic prev_q;
    logic held_q;

    assign fall_o = prev_q & ~pin_n_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            held_q <= 1'b0;
        end else begin
            prev_q <= pin_n_i;
            if (clr_i)                held_q <= 1'b0;
            else if (arm_i && fall_o) held_q <= 1'b1;
        end
    end

    assign held_o = held_q;

    // R6
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !held_q);
    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !clr_i) |=> held_q);
endmodule

// File: rtl/eic_masks.sv
module eic_masks (
    input  logic clk,
    input  logic rst_n,
    input  logic g_set_i,
    input  logic g_clr_i,
    input  logic n_set_i,
    input  logic n_clr_i,
    input  logic hw_g_set_i,
    input  logic hw_n_set_i,
    output logic gmask_next_o,
    output logic nmask_next_o,
    output logic gmask_o,
    output logic nmask_o
);
    logic gmask_q;
    logic nmask_q;

    always_comb begin
        if (g_set_i || hw_g_set_i) gmask_next_o = 1'b1;
        else if (g_clr_i)          gmask_next_o = 1'b0;
        else                       gmask_next_o = gmask_q;

        // the software set only keeps a mask that is still 1
        if (hw_n_set_i)              nmask_next_o = 1'b1;
        else if (n_clr_i)            nmask_next_o = 1'b0;
        else if (n_set_i && nmask_q) nmask_next_o = 1'b1;
        else                         nmask_next_o = nmask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gmask_q <= 1'b1;
            nmask_q <= 1'b1;
        end else begin
            gmask_q <= gmask_next_o;
            nmask_q <= nmask_next_o;
        end
    end

    assign gmask_o = gmask_q;
    assign nmask_o = nmask_q;

    // R8
    nmask_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmask_q && !hw_n_set_i) |=> !nmask_q);
    // R10
    ack_sets_gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_g_set_i |=> gmask_q);
    // R11
    gmask_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_set_i && g_clr_i) |=> gmask_q);
endmodule

// File: rtl/ext_int_ctrl.sv
module ext_int_ctrl
    import eic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mirq_pin_n,
    input  logic             nmi_pin_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             gmask_set,
    input  logic             gmask_clr,
    input  logic             nmask_set,
    input  logic             nmask_clr,
    input  logic             swi_stb,
    input  logic             int_ack,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec
);
    state_e           state_q, state_n;
    src_e             src_q, win_n;
    logic             req_q;
    logic [VEC_W-1:0] vec_q;
    logic             edge_q, en_q, edge_n, en_n;
    logic             swi_q, swi_n;
    logic             take, take_swi, take_nmi, take_mirq;
    logic [1:0]       sync_q;
    logic             mirq_s, nmi_s;
    logic             fall, held;
    logic             gmask_n, nmask_n, gmask_cur, nmask_cur;
    logic             mirq_act, nmi_act, any_act, mirq_raw;
    logic             unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:0], gmask_cur, nmask_cur};

    // pin conditioning
    eic_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({nmi_pin_n, mirq_pin_n}), .q_o(sync_q));
    assign mirq_s = sync_q[0];
    assign nmi_s  = sync_q[1];

    // acknowledge decode
    assign take      = int_ack & req_q;
    assign take_swi  = take & (src_q == SRC_SWI);
    assign take_nmi  = take & (src_q == SRC_NMI);
    assign take_mirq = take & (src_q == SRC_MIRQ);

    // control register next value
    assign edge_n = cfg_we ? cfg_wdata[CFG_EDGE_B] : edge_q;
    assign en_n   = cfg_we ? cfg_wdata[CFG_EN_B]   : en_q;

    eic_edge_latch u_edge (
        .clk(clk), .rst_n(rst_n), .pin_n_i(mirq_s), .arm_i(edge_n),
        .clr_i(take_mirq), .fall_o(fall), .held_o(held));

    eic_masks u_masks (
        .clk(clk), .rst_n(rst_n),
        .g_set_i(gmask_set), .g_clr_i(gmask_clr),
        .n_set_i(nmask_set), .n_clr_i(nmask_clr),
        .hw_g_set_i(take), .hw_n_set_i(take_nmi),
        .gmask_next_o(gmask_n), .nmask_next_o(nmask_n),
        .gmask_o(gmask_cur), .nmask_o(nmask_cur));

    // source activity after this cycle's updates
    always_comb begin
        swi_n    = swi_stb | (swi_q & ~take_swi);
        nmi_act  = ~nmi_s & ~nmask_n;
        if (edge_n) mirq_raw = ~take_mirq & (held | fall);
        else        mirq_raw = ~mirq_s;
        mirq_act = mirq_raw & en_n & ~gmask_n;
        any_act  = swi_n | nmi_act | mirq_act;
        if (swi_n)         win_n = SRC_SWI;
        else if (nmi_act)  win_n = SRC_NMI;
        else if (mirq_act) win_n = SRC_MIRQ;
        else               win_n = SRC_NONE;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_BOOT: if (any_act) state_n = ST_REQ;
            ST_IDLE: if (any_act) state_n = ST_REQ;
            ST_REQ:  if (!any_act) state_n = ST_IDLE;
            default: state_n = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            src_q   <= SRC_NONE;
            swi_q   <= 1'b0;
            edge_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            if (any_act) src_q <= win_n;
            swi_q   <= swi_n;
            edge_q  <= edge_n;
            en_q    <= en_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= VEC_RESET;
        end else begin
            req_q <= (state_n == ST_REQ);
            if (state_n == ST_REQ) vec_q <= vec_of(win_n);
        end
    end

    assign int_req = req_q;
    assign int_vec = vec_q;

    // R1
    boot_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> (!int_req && int_vec == VEC_RESET));
    // R2
    req_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_vec == VEC_SWI || int_vec == VEC_NMI || int_vec == VEC_MIRQ));
    // R9
    swi_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swi_stb |=> (int_req && int_vec == VEC_SWI));
    // R2
    idle_vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_req && state_q != ST_BOOT && !any_act) |=> $stable(int_vec));
endmodule

// File: tb/sim_ext_int_ctrl.sv
module sim_ext_int_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic mirq_pin_n = 1, nmi_pin_n = 1, cfg_we = 0;
    logic [7:0] cfg_wdata = 0;
    logic gmask_set = 0, gmask_clr = 0, nmask_set = 0, nmask_clr = 0;
    logic swi_stb = 0, int_ack = 0;
    logic int_req;
    logic [15:0] int_vec;

    int checks = 0, errors = 0, cyc = 0;

    ext_int_ctrl u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    bit m_req, m_gm, m_nm, m_edge, m_en, m_swi, m_held;
    int m_src;                // 0 none,1 swi,2 nmi,3 maskable
    logic [15:0] m_vec;
    bit m_mp[$], m_np[$];     // pin sample histories
    bit m_prev;

    function automatic logic [15:0] vec_for(int s);
        if (s == 1) return 16'hFFF6;
        if (s == 2) return 16'hFFF4;
        if (s == 3) return 16'hFFF2;
        return 16'hFFFE;
    endfunction

    always @(posedge clk) begin : model
        bit take, sw, na, ma, mlow, fl, gm, nm, ed, en, raw;
        int w;
        if (!rst_n) begin
            m_req = 0; m_vec = 16'hFFFE; m_gm = 1; m_nm = 1; m_edge = 0; m_en = 0;
            m_swi = 0; m_held = 0; m_src = 0; m_prev = 1;
            m_mp = '{1, 1}; m_np = '{1, 1};
        end else begin
            take = int_ack && m_req;
            ed = cfg_we ? cfg_wdata[7] : m_edge;
            en = cfg_we ? cfg_wdata[6] : m_en;
            gm = (gmask_set || take) ? 1 : (gmask_clr ? 0 : m_gm);
            if (take && m_src == 2) nm = 1;
            else if (nmask_clr) nm = 0;
            else nm = m_nm;
            sw = swi_stb || (m_swi && !(take && m_src == 1));
            mlow = (m_mp[0] == 0);
            fl = m_prev && mlow;
            raw = ed ? (!(take && m_src == 3) && (m_held || fl)) : mlow;
            ma = raw && en && !gm;
            na = (m_np[0] == 0) && !nm;
            w = sw ? 1 : (na ? 2 : (ma ? 3 : 0));
            if (take && m_src == 3) m_held = 0;
            else if (ed && fl) m_held = 1;
            m_prev = m_mp[0];
            void'(m_mp.pop_front()); m_mp.push_back(mirq_pin_n);
            void'(m_np.pop_front()); m_np.push_back(nmi_pin_n);
            m_gm = gm; m_nm = nm; m_edge = ed; m_en = en; m_swi = sw;
            m_req = (w != 0);
            if (w != 0) begin m_vec = vec_for(w); m_src = w; end
        end
    end

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(int_req == m_req, "R2 model req", {15'd0, int_req}, {15'd0, m_req});
            chk(int_vec == m_vec, "R3 model vec", int_vec, m_vec);
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(int n); repeat (n) @(negedge clk); endtask
    task automatic pulse(ref logic s); @(negedge clk); s = 1; @(negedge clk); s = 0; endtask
    task automatic wr_cfg(logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_wdata = d; @(negedge clk); cfg_we = 0;
    endtask
    task automatic ack; @(negedge clk); int_ack = 1; @(negedge clk); int_ack = 0; endtask
    task automatic expect_out(bit r, logic [15:0] v, string tag);
        chk(int_req == r, tag, {15'd0, int_req}, {15'd0, r});
        if (r) chk(int_vec == v, tag, int_vec, v);
    endtask

    initial begin
        step(3); rst_n = 1; step(1);
        expect_out(0, 0, "R1 reset req");
        chk(int_vec == 16'hFFFE, "R1 reset vector", int_vec, 16'hFFFE);
        // non-maskable pin blocked by reset mask
        nmi_pin_n = 0; step(6);
        expect_out(0, 0, "R1 nmask set at reset");
        nmi_pin_n = 1; step(4);
        // maskable pin: disabled locally and globally
        mirq_pin_n = 0; step(6);
        expect_out(0, 0, "R4 disabled after reset");
        pulse(gmask_clr); step(5);
        expect_out(0, 0, "R4 local enable off");
        wr_cfg(8'h40); step(5);
        expect_out(1, 16'hFFF2, "R5 level request");
        mirq_pin_n = 1; step(2);
        expect_out(1, 16'hFFF2, "R5 held through sync delay");
        step(3);
        expect_out(0, 0, "R5 released");
        chk(int_vec == 16'hFFF2, "R2 vector held while idle", int_vec, 16'hFFF2);
        pulse(gmask_set); mirq_pin_n = 0; step(5);
        expect_out(0, 0, "R4 global mask blocks");
        // priority and acknowledge side effects
        pulse(gmask_clr); pulse(nmask_clr); nmi_pin_n = 0; step(5);
        expect_out(1, 16'hFFF4, "R3 nmi over maskable");
        ack; step(1);
        expect_out(0, 0, "R10 ack sets both masks");
        nmi_pin_n = 1; mirq_pin_n = 1; step(4);
        // one-way mask
        pulse(nmask_clr); pulse(nmask_set); wr_cfg(8'h00); nmi_pin_n = 0; step(5);
        expect_out(1, 16'hFFF4, "R8 set ignored after clear");
        expect_out(1, 16'hFFF4, "R7 nmi with gmask set and cfg off");
        ack; nmi_pin_n = 1; step(4);
        expect_out(0, 0, "R10 nmi retired");
        // software interrupt
        pulse(swi_stb); step(0);
        expect_out(1, 16'hFFF6, "R9 swi next edge");
        ack; step(2);
        expect_out(0, 0, "R10 swi retired");
        pulse(nmask_clr); nmi_pin_n = 0; step(1);
        pulse(swi_stb);
        expect_out(1, 16'hFFF6, "R3 swi over nmi");
        ack; step(1);
        expect_out(1, 16'hFFF4, "R3 nmi follows swi");
        ack; nmi_pin_n = 1; step(4);
        // ack without request
        wr_cfg(8'h40); pulse(gmask_clr); ack; step(2);
        expect_out(0, 0, "R10 idle ack no request");
        mirq_pin_n = 0; step(5);
        expect_out(1, 16'hFFF2, "R10 idle ack left gmask clear");
        // set wins over clear
        ack; step(2);
        @(negedge clk); gmask_set = 1; gmask_clr = 1; @(negedge clk); gmask_set = 0; gmask_clr = 0;
        step(3);
        expect_out(0, 0, "R11 set wins");
        pulse(gmask_clr); step(2);
        expect_out(1, 16'hFFF2, "R11 clear alone");
        ack; mirq_pin_n = 1; step(4);
        // edge mode
        wr_cfg(8'hC0); pulse(gmask_clr);
        @(negedge clk); mirq_pin_n = 0; @(negedge clk); mirq_pin_n = 1;
        step(8);
        expect_out(1, 16'hFFF2, "R6 edge held");
        mirq_pin_n = 0; step(4);
        ack; pulse(gmask_clr); step(6);
        expect_out(0, 0, "R6 no retrigger while low");
        mirq_pin_n = 1; step(4);
        mirq_pin_n = 0; step(5);
        expect_out(1, 16'hFFF2, "R6 new edge");
        ack; step(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule